// File: doc/BRIEF.md
# Two-Wire Slave Byte Engine

This block is the bus-facing front end of a serial memory slave on a two-wire bus. It receives the clock line and the data line as inputs that are sampled by a much faster system clock, and it drives the data line through a single pull-low enable. It finds start and stop conditions and collects bytes with the most significant bit first. It decides whether the first byte after a start addresses this slave, drives the acknowledge bit, and shifts read data back to the master.

Toward the memory side it reports each accepted byte with its position in the transfer, the direction of the transfer, start and stop events, and the master's acknowledge after each byte it reads. From the memory side it takes the next byte to send and a flag that says an internal write is still running. While that flag is set, the slave stays silent when it is addressed, so the master can poll until the write is done.

Top module: `twsByteEngine`

## Requirements
- R1: After reset the data line is released (`sdaDriveLow` = 0) and no byte, start, stop or acknowledge event is reported.
- R2: A falling data line while the clock is high raises `startEvt` for one cycle. A rising data line while the clock is high raises `stopEvt` for one cycle. After a stop the data line is released.
- R3: The first byte after a start is taken as the control byte. Bits 7..4 are the device code 1010, bit 3 selects the block, bits 2 and 1 are chip-select bits that must equal `chipSel[1]` and `chipSel[0]`, and bit 0 gives the direction (1 = read). The byte is acknowledged only when both fields match. Otherwise the block gives no acknowledge and ignores the bus until the next start or stop.
- R4: The slave acknowledges by pulling the data line low for the whole ninth clock. The slave changes its drive only while the clock line is low.
- R5: In a write transfer, every received byte is acknowledged and reported with a one-cycle `rxValid`. `rxData` holds the byte, MSB first on the wire. `rxIndex` is 0 for the control byte and counts up from 1 for the following bytes, saturating at its maximum.
- R6: While `busy` is high, a matching control byte gets no acknowledge and no `rxValid`, and the following bytes are ignored.
- R7: In a read transfer, the slave sends `rdData` MSB first, starting after the control-byte acknowledge. After each byte it reports the master's acknowledge bit on `mackValid`/`mackAck` (`mackAck` = 1 when the line was low). A master acknowledge makes the slave send a new byte, taken from `rdData` at the end of that acknowledge clock.
- R8: A master not-acknowledge leaves the data line released, and the slave ignores the bus until the next start or stop.
- R9: A repeated start in the middle of a transfer ends it and restarts control-byte reception. The next accepted byte is again reported with `rxIndex` 0.
- R10: `rwFlag` holds bit 0 of the most recently accepted control byte.
- R11: With `selHigh` low the slave never acknowledges, even if the control byte matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as sampled |
| sdaIn | input | 1 | Bus data line as sampled (wired level) |
| sdaDriveLow | output | 1 | 1 = pull the data line low |
| chipSel | input | 2 | Strapped chip-select levels |
| selHigh | input | 1 | Strapped third select; must be 1 for the slave to respond |
| busy | input | 1 | Internal write in progress |
| rdData | input | 8 | Next byte to send on a read |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle pulse when an accepted byte is reported |
| rxIndex | output | IDX_W | Position of the reported byte in the transfer |
| rwFlag | output | 1 | Direction of the current transfer, 1 = read |
| startEvt | output | 1 | Start or repeated start seen |
| stopEvt | output | 1 | Stop seen |
| mackValid | output | 1 | Master acknowledge bit sampled on a read |
| mackAck | output | 1 | 1 = the master acknowledged |

## Verification
The bench attacks the address decoding with a wrong chip select, a wrong device code, the third select pulled low, and a correct address sent while `busy` is high. A decoder that skips any of these checks would acknowledge and report bytes where the bus must stay silent. In reads it checks that the first data bit comes right after the control acknowledge and that a second byte is fetched only after a master acknowledge. A slave that took the control acknowledge for a master acknowledge, or that kept driving after a not-acknowledge, would corrupt the data or hold the line. A repeated start placed after a data byte shows whether the byte index and the direction flag are restarted. A monitor on the slave's drive catches any change made while the clock line is high, which would create false start or stop conditions.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CACK,
    ST_WRITE,
    ST_READ
  } state_e;

  typedef struct packed {
    logic clrBit;
    logic clrIdx;
    logic incIdx;
    logic relSda;
    logic driveAck;
    logic loadTx;
    logic shiftTx;
  } strobe_t;
endpackage

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rdData,
  input  strobe_t           ctl,
  output logic              sdaS,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [BYTE_W-1:0] rxByte,
  output logic [IDX_W-1:0]  byteIdx,
  output logic              sdaDriveLow
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sclP, sdaP;
  logic [BYTE_W-1:0] txShift;

  // synchronizer chains, reset to the idle bus level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclP <= sclS;
      sdaP <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];
  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet = sclS & sclP & ~sdaP & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxByte <= '0;
    end else begin
      if (ctl.clrBit) bitCnt <= '0;
      else if (sclRise) bitCnt <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
      if (sclRise && bitCnt != LAST) rxByte <= {rxByte[BYTE_W-2:0], sdaS};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      sdaDriveLow <= 1'b0;
    end else if (ctl.relSda) begin
      sdaDriveLow <= 1'b0;
    end else if (ctl.driveAck) begin
      sdaDriveLow <= 1'b1;
    end else if (ctl.loadTx) begin
      txShift <= rdData;
      sdaDriveLow <= ~rdData[BYTE_W-1];
    end else if (ctl.shiftTx) begin
      txShift <= {txShift[BYTE_W-2:0], 1'b0};
      sdaDriveLow <= ~txShift[BYTE_W-2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) byteIdx <= '0;
    else if (ctl.clrIdx) byteIdx <= '0;
    else if (ctl.incIdx && byteIdx != IDX_MAX) byteIdx <= byteIdx + 1'b1;
  end

  // R4: the slave starts pulling low only while the clock line is low
  p_drive_scl_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclS);

  // R5: byte framing never goes past the acknowledge bit
  p_bitcnt_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST);
endmodule

// File: rtl/tws_control.sv
module tws_control
  import tws_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sdaS,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [1:0]        chipSel,
  input  logic              selHigh,
  input  logic              busy,
  output strobe_t           ctl,
  output logic              rxValid,
  output logic              rwFlag,
  output logic              mackValid,
  output logic              mackAck
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  state_e state, nxt;
  logic rwNxt, byteEnd, ackEnd, ninthRise, match;

  assign byteEnd = sclFall && bitCnt == LAST;
  assign ackEnd = sclFall && bitCnt == '0;
  assign ninthRise = sclRise && bitCnt == LAST;
  assign match = selHigh && rxByte[7:4] == DEV_CODE && rxByte[2:1] == chipSel;
  assign mackAck = ~sdaS;

  always_comb begin
    ctl = '0;
    nxt = state;
    rwNxt = rwFlag;
    rxValid = 1'b0;
    mackValid = 1'b0;
    if (startDet) begin
      ctl.clrBit = 1'b1;
      ctl.clrIdx = 1'b1;
      ctl.relSda = 1'b1;
      nxt = ST_CTRL;
    end else if (stopDet) begin
      ctl.clrBit = 1'b1;
      ctl.clrIdx = 1'b1;
      ctl.relSda = 1'b1;
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_CTRL: if (byteEnd) begin
          if (match && !busy) begin
            ctl.driveAck = 1'b1;
            ctl.incIdx = 1'b1;
            rxValid = 1'b1;
            rwNxt = rxByte[0];
            nxt = ST_CACK;
          end else begin
            nxt = ST_IDLE;
          end
        end
        ST_CACK: if (ackEnd) begin
          if (rwFlag) begin
            ctl.loadTx = 1'b1;
            nxt = ST_READ;
          end else begin
            ctl.relSda = 1'b1;
            nxt = ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (byteEnd) begin
            ctl.driveAck = 1'b1;
            ctl.incIdx = 1'b1;
            rxValid = 1'b1;
          end else if (ackEnd) begin
            ctl.relSda = 1'b1;
          end
        end
        ST_READ: begin
          if (ninthRise) begin
            mackValid = 1'b1;
            if (sdaS) nxt = ST_IDLE;
          end else if (ackEnd) begin
            ctl.loadTx = 1'b1;
          end else if (byteEnd) begin
            ctl.relSda = 1'b1;
          end else if (sclFall) begin
            ctl.shiftTx = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      rwFlag <= 1'b0;
    end else begin
      state <= nxt;
      rwFlag <= rwNxt;
    end
  end

  // R6: no control acknowledge is started while the write is busy
  p_no_ack_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CACK && $past(state) == ST_CTRL) |-> !$past(busy));

  // R3: an acknowledged control byte carried the device code
  p_code_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CACK && $past(state) == ST_CTRL) |->
      ($past(rxByte[7:4]) == DEV_CODE && $past(selHigh)));

  // R8: a master not-acknowledge ends the read
  p_nack_ends_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mackValid && !mackAck) |=> state == ST_IDLE);
endmodule

// File: rtl/twsByteEngine.sv
module twsByteEngine
  import tws_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic [1:0]        chipSel,
  input  logic              selHigh,
  input  logic              busy,
  input  logic [7:0]        rdData,
  output logic [7:0]        rxData,
  output logic              rxValid,
  output logic [IDX_W-1:0]  rxIndex,
  output logic              rwFlag,
  output logic              startEvt,
  output logic              stopEvt,
  output logic              mackValid,
  output logic              mackAck
);
  strobe_t ctl;
  logic sdaS, sclRise, sclFall, startDet, stopDet;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] rxByte;
  logic [IDX_W-1:0] byteIdx;

  tws_datapath #(.SYNC_STAGES(SYNC_STAGES), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .rdData(rdData),
    .ctl(ctl), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .bitCnt(bitCnt),
    .rxByte(rxByte), .byteIdx(byteIdx), .sdaDriveLow(sdaDriveLow)
  );

  tws_control uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaS(sdaS), .bitCnt(bitCnt),
    .rxByte(rxByte), .chipSel(chipSel), .selHigh(selHigh), .busy(busy),
    .ctl(ctl), .rxValid(rxValid), .rwFlag(rwFlag),
    .mackValid(mackValid), .mackAck(mackAck)
  );

  assign rxData = rxByte;
  assign rxIndex = byteIdx;
  assign startEvt = startDet;
  assign stopEvt = stopDet;

  // R2: the line is free once a stop is seen
  p_release_on_stop_r2: assert property (@(posedge clk) disable iff (!rstN)
    stopEvt |=> !sdaDriveLow);
endmodule

// File: tb/tb_twsByteEngine.sv
module tb_twsByteEngine;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 4;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclReg = 1'b1;
  logic sdaM = 1'b1;
  logic sdaBus;
  logic sdaDriveLow;
  logic [1:0] chipSel = 2'b10;
  logic selHigh = 1'b1;
  logic busy = 1'b0;
  logic [7:0] rdData = 8'h00;
  logic [7:0] rxData;
  logic rxValid, rwFlag, startEvt, stopEvt, mackValid, mackAck;
  logic [IDX_W-1:0] rxIndex;

  int nChecks = 0, nFail = 0;
  int rxCnt = 0, startCnt = 0, stopCnt = 0, mackCnt = 0, highChanges = 0;
  logic [7:0] rxLogD [16];
  int rxLogI [16];
  logic mackLog [16];
  logic prevDrv = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaBus = sdaM & ~sdaDriveLow;

  twsByteEngine #(.IDX_W(IDX_W)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclReg), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .chipSel(chipSel), .selHigh(selHigh),
    .busy(busy), .rdData(rdData), .rxData(rxData), .rxValid(rxValid),
    .rxIndex(rxIndex), .rwFlag(rwFlag), .startEvt(startEvt),
    .stopEvt(stopEvt), .mackValid(mackValid), .mackAck(mackAck)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid && rxCnt < 16) begin
        rxLogD[rxCnt] = rxData;
        rxLogI[rxCnt] = int'(rxIndex);
      end
      if (rxValid) rxCnt++;
      if (startEvt) startCnt++;
      if (stopEvt) stopCnt++;
      if (mackValid && mackCnt < 16) mackLog[mackCnt] = mackAck;
      if (mackValid) mackCnt++;
      if (sdaDriveLow != prevDrv && sclReg) highChanges++;
      prevDrv = sdaDriveLow;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearLog();
    rxCnt = 0; startCnt = 0; stopCnt = 0; mackCnt = 0;
  endtask

  task automatic bitClk(input logic b, output logic s);
    waitClk(Q); sdaM = b;
    waitClk(Q); sclReg = 1'b1;
    waitClk(Q); s = sdaBus;
    waitClk(Q); sclReg = 1'b0;
  endtask

  task automatic busStart();
    waitClk(Q); sdaM = 1'b1;
    waitClk(Q); sclReg = 1'b1;
    waitClk(Q); sdaM = 1'b0;
    waitClk(Q); sclReg = 1'b0;
  endtask

  task automatic busStop();
    waitClk(Q); sdaM = 1'b0;
    waitClk(Q); sclReg = 1'b1;
    waitClk(Q); sdaM = 1'b1;
    waitClk(2*Q);
  endtask

  task automatic sendByte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bitClk(d[i], s);
    bitClk(1'b1, s);
    acked = ~s;
  endtask

  task automatic recvByte(input logic ack, input logic [7:0] nextData,
                          output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      bitClk(1'b1, s);
      d = {d[6:0], s};
    end
    rdData = nextData;
    bitClk(~ack, s);
  endtask

  task automatic tReset();
    check(sdaDriveLow == 1'b0, "R1", "drive after reset", sdaDriveLow, 0);
    check(rxValid == 1'b0 && startEvt == 1'b0 && stopEvt == 1'b0 && mackValid == 1'b0,
          "R1", "events after reset", {rxValid, startEvt, stopEvt, mackValid}, 0);
  endtask

  task automatic tWrite();
    logic a0, a1, a2;
    clearLog();
    busStart();
    sendByte(8'hA4, a0);
    sendByte(8'h5A, a1);
    sendByte(8'hC3, a2);
    busStop();
    check(a0, "R3", "control ack", a0, 1);
    check(a1 && a2, "R5", "data acks", {a1, a2}, 3);
    check(rxCnt == 3, "R5", "byte count", rxCnt, 3);
    check(rxLogD[0] == 8'hA4 && rxLogI[0] == 0, "R5", "control entry", rxLogD[0], 8'hA4);
    check(rxLogD[1] == 8'h5A && rxLogI[1] == 1, "R5", "byte 1", rxLogD[1], 8'h5A);
    check(rxLogD[2] == 8'hC3 && rxLogI[2] == 2, "R5", "byte 2", rxLogD[2], 8'hC3);
    check(rwFlag == 1'b0, "R10", "write direction", rwFlag, 0);
    check(startCnt == 1 && stopCnt == 1, "R2", "start/stop events",
          startCnt * 16 + stopCnt, 17);
    check(sdaDriveLow == 1'b0, "R2", "released after stop", sdaDriveLow, 0);
  endtask

  task automatic tRead();
    logic a, a2;
    logic [7:0] d0, d1;
    clearLog();
    rdData = 8'h96;
    busStart();
    sendByte(8'hA5, a);
    recvByte(1'b1, 8'h3C, d0);
    recvByte(1'b0, 8'hFF, d1);
    check(a, "R7", "read control ack", a, 1);
    check(rwFlag == 1'b1, "R10", "read direction", rwFlag, 1);
    check(d0 == 8'h96, "R7", "first read byte", d0, 8'h96);
    check(d1 == 8'h3C, "R7", "second read byte", d1, 8'h3C);
    check(mackCnt == 2 && mackLog[0] == 1'b1 && mackLog[1] == 1'b0, "R7",
          "master ack events", mackCnt, 2);
    check(sdaDriveLow == 1'b0, "R8", "released after nack", sdaDriveLow, 0);
    sendByte(8'hA4, a2);
    check(!a2 && rxCnt == 1, "R8", "ignored after nack", {a2, 4'(rxCnt)}, 1);
    busStop();
  endtask

  task automatic tBusy();
    logic a, b;
    clearLog();
    busy = 1'b1;
    busStart();
    sendByte(8'hA4, a);
    sendByte(8'h11, b);
    busStop();
    busy = 1'b0;
    check(!a, "R6", "no ack while busy", a, 0);
    check(!b && rxCnt == 0, "R6", "bytes ignored while busy", rxCnt, 0);
  endtask

  task automatic tNoMatch();
    logic a, b, c;
    clearLog();
    busStart();
    sendByte(8'hA2, a);
    sendByte(8'h00, b);
    busStop();
    busStart();
    sendByte(8'hB4, c);
    busStop();
    check(!a, "R3", "wrong chip select", a, 0);
    check(!b, "R3", "ignored after mismatch", b, 0);
    check(!c, "R3", "wrong device code", c, 0);
    check(rxCnt == 0, "R3", "no bytes reported", rxCnt, 0);
  endtask

  task automatic tSelLow();
    logic a;
    clearLog();
    selHigh = 1'b0;
    busStart();
    sendByte(8'hA4, a);
    busStop();
    selHigh = 1'b1;
    check(!a && rxCnt == 0, "R11", "third select low", a, 0);
  endtask

  task automatic tRestart();
    logic a0, a1, a2;
    logic [7:0] d;
    clearLog();
    rdData = 8'h71;
    busStart();
    sendByte(8'hAC, a0);
    sendByte(8'h07, a1);
    busStart();
    sendByte(8'hA5, a2);
    recvByte(1'b0, 8'h00, d);
    busStop();
    check(a0 && a1 && a2, "R9", "acks around restart", {a0, a1, a2}, 7);
    check(startCnt == 2, "R9", "two starts", startCnt, 2);
    check(rxCnt == 3 && rxLogD[2] == 8'hA5 && rxLogI[2] == 0, "R9",
          "index restarts", rxLogI[2], 0);
    check(rxLogD[0] == 8'hAC, "R3", "block bit passed up", rxLogD[0], 8'hAC);
    check(d == 8'h71 && rwFlag == 1'b1, "R10", "read after restart", d, 8'h71);
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    tReset();
    tWrite();
    tRead();
    tBusy();
    tNoMatch();
    tSelLow();
    tRestart();
    check(highChanges == 0, "R4", "drive changed with clock high", highChanges, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule